// File: doc/BRIEF.md
# Sixteen-bit reload down-counting timer

This block is a 16-bit down-counter that decrements on ticks taken from a prescaled version of its own clock. Software programs a reload value and a 12-bit control word through a small synchronous register bus, then starts the count with a trigger bit. When the counter steps from 0000h to FFFFh (an underflow), the block does one of two things. In reload mode it reloads the programmed value and keeps counting. In one-shot mode it parks at FFFFh and waits for another trigger.

Every underflow sets a sticky flag. The interrupt request output is high while both that flag and the interrupt enable are set. The clock select, reload enable and interrupt enable can be changed only while counting is disabled. The enable bit, the flag and the trigger can be written at any time. The mode and pin-output bits of the control word are reserved: they are not stored and always read back as zero.

Bus map: address 0 is the control word, address 1 is the reload register (read/write at any time), address 2 is the live counter (read only), and address 3 reads as zero. Read data is combinational from the address. Writes take effect at the clock edge where the write strobe is high.

Top module: `rld_timer16`

## Requirements
- R1: After reset the control word, reload register and counter all read 0, and `irq` is 0.
- R2: The control word has the following layout: bits 11:10 clock select, bit 4 reload enable, bit 3 interrupt enable, bit 2 underflow flag, bit 1 count enable, bit 0 trigger. Bits 15:12 and 9:5 always read 0, whatever was written to them.
- R3: Clock select 0, 1 and 2 give one counter decrement every 2, 8 and 32 clocks. The first decrement lands on the Nth rising edge after the trigger edge.
- R4: With clock select 3 the counter never changes after a trigger.
- R5: A control write with bit 1 = 1 and bit 0 = 1 loads the reload value into the counter and starts counting. Bit 0 always reads 0.
- R6: With reload enable = 1, the tick that finds the counter at 0 loads the reload value and counting continues.
- R7: With reload enable = 0, the tick that finds the counter at 0 sets it to FFFFh and stops counting while bit 1 stays 1. A new trigger restarts from the reload value.
- R8: Every underflow sets the flag. Writing 0 to bit 2 clears it, and writing 1 to bit 2 leaves it unchanged.
- R9: `irq` equals the flag AND the interrupt enable.
- R10: While bit 1 reads 1, writes to bits 11:10, 4 and 3 are ignored.
- R11: Writing bit 1 = 0 stops the counter, which then holds its value. Setting bit 1 again without a trigger does not resume counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count ticks are derived from it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Register address: 0 control, 1 reload, 2 counter, 3 none |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request, flag AND interrupt enable |

## Verification
The bench sweeps every usable clock select against reload values of 0, 2 and 5 in both modes. It compares the counter on every clock against a value it computes from the number of elapsed prescaled ticks. An off-by-one in the prescaler phase, or a prescaler that is not cleared at the trigger, shows up as a counter that changes a cycle early or late. A reload that loads FFFFh, or that skips the zero count, breaks the periodic sequence. A one-shot stop that fails to park would show the counter wrapping past FFFFh. Separate cases cover:
- the flag ignoring a written 1;
- configuration writes being dropped while enabled;
- the dead clock-select code 3;
- a disabled counter resuming without a trigger.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_W = 12;

  typedef enum logic [1:0] {
    CLK_DIV_A = 2'd0,
    CLK_DIV_B = 2'd1,
    CLK_DIV_C = 2'd2,
    CLK_NONE  = 2'd3
  } clk_sel_e;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_RLD = 2'd1;
  localparam logic [1:0] ADDR_CNT = 2'd2;

  localparam int B_TRG = 0;
  localparam int B_EN  = 1;
  localparam int B_FLG = 2;
  localparam int B_IE  = 3;
  localparam int B_RLD = 4;
  localparam int B_SEL = 10;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int LOG_A = 1,
  parameter int LOG_B = 3,
  parameter int LOG_C = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     run_i,
  input  clk_sel_e sel_i,
  output logic     tick_o
);
  localparam int PW = LOG_C;
  localparam logic [PW-1:0] MASK_A = PW'((1 << LOG_A) - 1);
  localparam logic [PW-1:0] MASK_B = PW'((1 << LOG_B) - 1);
  localparam logic [PW-1:0] MASK_C = PW'((1 << LOG_C) - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [PW-1:0] mask;
  logic          sel_ok;

  always_comb begin
    sel_ok = 1'b1;
    mask   = MASK_A;
    case (sel_i)
      CLK_DIV_A: mask = MASK_A;
      CLK_DIV_B: mask = MASK_B;
      CLK_DIV_C: mask = MASK_C;
      default:   sel_ok = 1'b0;
    endcase
  end

  always_comb begin
    pre_d = pre_q;
    if (clr_i)      pre_d = '0;
    else if (run_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = run_i & ~clr_i & sel_ok & ((pre_q & mask) == mask);

  // R4
  no_tick_on_dead_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == CLK_NONE) |-> !tick_o);
  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic             reload_en_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             underflow_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             at_zero;

  assign at_zero     = (cnt_q == '0);
  assign underflow_o = tick_i & at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = reload_val_i;
    else if (underflow_o)    cnt_d = reload_en_i ? reload_val_i : '1;
    else if (tick_i)         cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    run_d = run_q;
    if (stop_i)                           run_d = 1'b0;
    else if (load_i)                      run_d = 1'b1;
    else if (underflow_o && !reload_en_i) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign running_o = run_q;

  // R6
  reload_on_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_o && reload_en_i && !load_i && !stop_i) |=> (cnt_q == $past(reload_val_i)) && run_q);
  // R7
  oneshot_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_o && !reload_en_i && !load_i) |=> (cnt_q == '1) && !run_q);
  // R11
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic [15:0]      wdata_i,
  input  logic             underflow_i,
  input  logic [CNT_W-1:0] cnt_i,
  output clk_sel_e         sel_o,
  output logic             reload_en_o,
  output logic             irq_en_o,
  output logic             flag_o,
  output logic             trig_o,
  output logic             stop_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [15:0]      rdata_o
);
  clk_sel_e         sel_q, sel_d;
  logic             rld_q, rld_d;
  logic             ie_q, ie_d;
  logic             en_q, en_d;
  logic             flg_q, flg_d;
  logic [CNT_W-1:0] rv_q, rv_d;
  logic             ctl_wr, cfg_we;
  logic             unused_bits;

  assign ctl_wr      = wr_i && (addr_i == ADDR_CTL);
  assign cfg_we      = ctl_wr && !en_q;
  assign unused_bits = ^{wdata_i[15:12], wdata_i[9:5]};

  always_comb begin
    sel_d = sel_q;
    rld_d = rld_q;
    ie_d  = ie_q;
    en_d  = en_q;
    flg_d = flg_q;
    rv_d  = rv_q;
    if (cfg_we) begin
      sel_d = clk_sel_e'(wdata_i[B_SEL+1:B_SEL]);
      rld_d = wdata_i[B_RLD];
      ie_d  = wdata_i[B_IE];
    end
    if (ctl_wr) en_d = wdata_i[B_EN];
    if (underflow_i)                    flg_d = 1'b1;
    else if (ctl_wr && !wdata_i[B_FLG]) flg_d = 1'b0;
    if (wr_i && (addr_i == ADDR_RLD)) rv_d = wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= CLK_DIV_A;
      rld_q <= 1'b0;
      ie_q  <= 1'b0;
      en_q  <= 1'b0;
      flg_q <= 1'b0;
      rv_q  <= '0;
    end else begin
      sel_q <= sel_d;
      rld_q <= rld_d;
      ie_q  <= ie_d;
      en_q  <= en_d;
      flg_q <= flg_d;
      rv_q  <= rv_d;
    end
  end

  assign trig_o = ctl_wr && wdata_i[B_EN] && wdata_i[B_TRG];
  assign stop_o = ctl_wr && !wdata_i[B_EN];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTL: rdata_o = {4'b0, sel_q, 5'b0, rld_q, ie_q, flg_q, en_q, 1'b0};
      ADDR_RLD: rdata_o = 16'(rv_q);
      ADDR_CNT: rdata_o = 16'(cnt_i);
      default:  rdata_o = '0;
    endcase
  end

  assign sel_o       = sel_q;
  assign reload_en_o = rld_q;
  assign irq_en_o    = ie_q;
  assign flag_o      = flg_q;
  assign reload_o    = rv_q;

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(sel_q) && $stable(rld_q) && $stable(ie_q)));
  // R8
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q) |-> $past(underflow_i));
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata_i[B_FLG] && !underflow_i) |=> !flg_q);
endmodule

// File: rtl/rld_timer16.sv
module rld_timer16
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LOG_A = 1,
  parameter int LOG_B = 3,
  parameter int LOG_C = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  logic [1:0]       rst_sync;
  logic             rst_i;
  clk_sel_e         sel;
  logic             reload_en, irq_en, flag, trig, stop;
  logic             tick, running, underflow;
  logic [CNT_W-1:0] reload_val, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  tmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_i), .addr_i(bus_addr), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .underflow_i(underflow), .cnt_i(cnt),
    .sel_o(sel), .reload_en_o(reload_en), .irq_en_o(irq_en),
    .flag_o(flag), .trig_o(trig), .stop_o(stop), .reload_o(reload_val),
    .rdata_o(bus_rdata)
  );

  tmr_prescaler #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) pre_i (
    .clk(clk), .rst_n(rst_i), .clr_i(trig), .run_i(running),
    .sel_i(sel), .tick_o(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_i), .load_i(trig), .stop_i(stop), .tick_i(tick),
    .reload_en_i(reload_en), .reload_val_i(reload_val), .cnt_o(cnt),
    .running_o(running), .underflow_o(underflow)
  );

  assign irq = flag & irq_en;

  // R7
  stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !running |-> !tick);
endmodule

// File: tb/rld_timer16_tb.sv
module rld_timer16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  rld_timer16 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd, a0;
    int rv, nd, d, tot;
    logic [15:0] exp;
    idle(3); rst_n = 1'b1; idle(4);

    // R1 reset state
    bus_read(2'd0, rd); chk("R1 ctl", rd, 16'h0000);
    bus_read(2'd1, rd); chk("R1 reload", rd, 16'h0000);
    bus_read(2'd2, rd); chk("R1 counter", rd, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'h0000);

    // R2 reserved bits read zero, layout
    bus_write(2'd0, 16'hFBF8);
    bus_read(2'd0, rd); chk("R2 layout", rd, 16'h0818);
    bus_read(2'd3, rd); chk("R2 addr3", rd, 16'h0000);

    // R3 R6 R7 sweep: clock select x reload value x mode
    for (int s = 0; s < 3; s++)
      for (int ri = 0; ri < 3; ri++)
        for (int md = 0; md < 2; md++) begin
          rv = (ri == 0) ? 0 : (ri == 1) ? 2 : 5;
          nd = 2 << (2 * s);
          bus_write(2'd0, 16'h0000);
          bus_write(2'd1, 16'(rv));
          bus_write(2'd0, 16'((s << 10) | (md << 4) | 16'h0007));
          tot = (rv + 2) * nd + 3;
          for (int m = 1; m <= tot; m++) begin
            @(posedge clk); #1;
            bus_read(2'd2, rd);
            d = m / nd;
            if (md == 1) exp = 16'(rv - (d % (rv + 1)));
            else         exp = (d <= rv) ? 16'(rv - d) : 16'hFFFF;
            chk(d <= rv ? "R3 decrement" : (md == 1 ? "R6 reload" : "R7 park"), rd, exp);
          end
          bus_read(2'd0, rd);
          chk("R8 flag set", {15'b0, rd[2]}, 16'h0001);
          chk("R5 trg reads 0", {15'b0, rd[0]}, 16'h0000);
          if (md == 0) begin
            chk("R7 enable stays", {15'b0, rd[1]}, 16'h0001);
            bus_write(2'd0, 16'(((s << 10) | 16'h0007)));
            bus_read(2'd2, rd); chk("R7 restart", rd, 16'(rv));
          end
        end

    // R4 dead clock select
    bus_write(2'd0, 16'h0000);
    bus_write(2'd1, 16'd9);
    bus_write(2'd0, 16'h0C07);
    bus_read(2'd2, rd); chk("R5 load", rd, 16'd9);
    idle(100);
    bus_read(2'd2, rd); chk("R4 hold", rd, 16'd9);

    // R10 config ignored while enabled
    bus_write(2'd0, 16'h001E);
    bus_read(2'd0, rd); chk("R10 cfg frozen", rd, 16'h0C02);
    idle(40);
    bus_read(2'd2, rd); chk("R10 sel unchanged", rd, 16'd9);

    // R11 stop holds, re-enable without trigger stays stopped
    bus_write(2'd0, 16'h0000);
    bus_write(2'd1, 16'd100);
    bus_write(2'd0, 16'h0007);
    idle(10);
    bus_write(2'd0, 16'h0004);
    bus_read(2'd2, a0);
    idle(20);
    bus_read(2'd2, rd); chk("R11 hold", rd, a0);
    bus_write(2'd0, 16'h0006);
    idle(20);
    bus_read(2'd2, rd); chk("R11 no resume", rd, a0);
    chk("R11 moved before stop", {15'b0, a0 < 16'd100}, 16'h0001);

    // R8 R9 flag and irq
    bus_write(2'd0, 16'h0000);
    bus_write(2'd1, 16'd0);
    bus_write(2'd0, 16'h000F);
    idle(6);
    chk("R9 irq high", {15'b0, irq}, 16'h0001);
    bus_write(2'd0, 16'h000E);
    bus_read(2'd0, rd); chk("R8 write 1 no effect", {15'b0, rd[2]}, 16'h0001);
    bus_write(2'd0, 16'h000A);
    bus_read(2'd0, rd); chk("R8 clear", {15'b0, rd[2]}, 16'h0000);
    chk("R9 irq low", {15'b0, irq}, 16'h0000);
    bus_write(2'd0, 16'h0000);
    bus_write(2'd0, 16'h0007);
    idle(6);
    bus_read(2'd0, rd); chk("R8 flag", {15'b0, rd[2]}, 16'h0001);
    chk("R9 masked", {15'b0, irq}, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule